// File: doc/BRIEF.md
# PS/2 Host Receive Engine

This block is the host end of a two-wire, open-collector PS/2 link. It takes in the device-to-host traffic only. Both raw line levels are brought into the system clock domain. The clock line is then filtered so that short spikes are ignored. Each clean falling edge of the line clock captures one bit from the data line. An eleven-bit frame is checked for shape and for odd parity, and a good byte goes into a single-entry holding buffer.

While that buffer holds a byte, the block pulls the bus clock low so the device cannot start another frame. The hold-off lasts for at least a minimum number of cycles. Software acknowledges the byte with a one-cycle read strobe, which empties the buffer. The clock line is let go once the buffer is empty and the minimum hold-off has passed. A malformed frame or a frame with bad parity is dropped and reported on its own flag.

Top module: `ps2_host_rx`

## Requirements
- R1: After reset the buffer is empty, the clock pull is off, both error flags are low and the byte output is 0x00.
- R2: A frame is one start bit of 0, eight data bits least significant first, a parity bit and a stop bit of 1. Each bit is taken at a filtered falling edge of the line clock. A good frame puts its byte on `rx_byte_o` and raises `rx_full_o`.
- R3: Parity is odd: the eight data bits together with the parity bit must hold an odd number of ones. A frame that fails this raises `parity_err_o`. It leaves the buffer and the byte output unchanged and does not pull the clock.
- R4: A start bit of 1 or a stop bit of 0 raises `frame_err_o` and drops the frame, whatever its parity.
- R5: The two error flags describe the most recently completed frame. They are never high together, and a good frame clears both.
- R6: `ps2_clk_pull_o` (1 = drive the line clock low) rises together with `rx_full_o` and stays high for as long as the buffer is full.
- R7: Once raised, the clock pull stays high for at least `INHIB_MIN` cycles, even if the byte is read earlier.
- R8: A read strobe while the buffer is full empties it on that clock edge. If `INHIB_MIN` cycles have already passed, the clock pull drops on the same edge.
- R9: Clock activity while the block pulls the line low adds no bits. The frame that follows the release is received intact.
- R10: A partial frame that sees no falling edge for `TMO_CYC` cycles is abandoned. The next frame is received from its start bit.
- R11: A low pulse on the clock line shorter than `FILT_LEN` cycles (after synchronization) is not taken as an edge.
- R12: A read strobe while the buffer is empty has no effect. The byte output changes only when a good frame is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps2_clk_i | input | 1 | Raw level of the bus clock line |
| ps2_dat_i | input | 1 | Raw level of the bus data line |
| ps2_clk_pull_o | output | 1 | 1 = drive the bus clock line low (inhibit) |
| rx_byte_o | output | 8 | Last byte received correctly |
| rx_full_o | output | 1 | Holding buffer occupied |
| rd_ack_i | input | 1 | One-cycle read strobe that empties the buffer |
| parity_err_o | output | 1 | Last frame failed the odd parity check |
| frame_err_o | output | 1 | Last frame had a bad start or stop bit |

## Verification
The assertions check the buffer and inhibit handshake on every cycle. The pull is high whenever the buffer is full, and no release comes before the minimum hold-off. A read strobe empties a full buffer, the error flags never rise together, and the byte output moves only when a completed frame fills the buffer. The bench scenarios are what show correct bit order and parity decisions on concrete bytes. They also show that spikes are rejected, that stalled partial frames are dropped after the timeout, and that clock toggling during an inhibit leaves no stray bits behind.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;
  localparam int FRAME_W = 11;

  // Frame bit 0 is the first bit on the wire (start), bit 10 the last (stop).
  function automatic logic frame_shape_ok(input logic [FRAME_W-1:0] f);
    return (f[0] == 1'b0) && (f[FRAME_W-1] == 1'b1);
  endfunction

  // Data bits plus parity bit must carry an odd number of ones.
  function automatic logic frame_parity_ok(input logic [FRAME_W-1:0] f);
    return ^f[9:1];
  endfunction

  function automatic logic [7:0] frame_payload(input logic [FRAME_W-1:0] f);
    return f[8:1];
  endfunction
endpackage

// File: rtl/ps2rx_sync.sv
module ps2rx_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  // Idle bus is high, so both stages reset to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      stab_q <= '1;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/ps2rx_deglitch.sv
module ps2rx_deglitch #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_i,
  output logic level_o,
  output logic fall_o
);
  localparam int CW = $clog2(LEN + 1);

  logic          level_q, fall_q;
  logic [CW-1:0] run_q;
  logic          differ, settle;

  assign differ = (in_i != level_q);
  assign settle = differ && (run_q == CW'(LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b1;
      run_q   <= '0;
      fall_q  <= 1'b0;
    end else begin
      fall_q <= settle && !in_i;
      if (settle) begin
        level_q <= in_i;
        run_q   <= '0;
      end else if (differ) begin
        run_q <= run_q + 1'b1;
      end else begin
        run_q <= '0;
      end
    end
  end

  assign level_o = level_q;
  assign fall_o  = fall_q;
endmodule

// File: rtl/ps2rx_framer.sv
module ps2rx_framer
  import ps2rx_pkg::*;
#(
  parameter int TMO_CYC = 250000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fall_i,
  input  logic               bit_i,
  input  logic               en_i,
  output logic               take_o,
  output logic               done_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int CW = $clog2(TMO_CYC + 1);
  localparam logic [3:0] LAST_BIT = 4'(FRAME_W - 1);

  logic [FRAME_W-2:0] shift_q;
  logic [FRAME_W-1:0] frame_q;
  logic [3:0]         pos_q;
  logic [CW-1:0]      quiet_q;
  logic               done_q;

  assign take_o = fall_i && en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      frame_q <= '0;
      pos_q   <= '0;
      quiet_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (take_o) begin
        quiet_q <= '0;
        if (pos_q == LAST_BIT) begin
          frame_q <= {bit_i, shift_q};
          done_q  <= 1'b1;
          pos_q   <= '0;
        end else begin
          shift_q <= {bit_i, shift_q[FRAME_W-2:1]};
          pos_q   <= pos_q + 1'b1;
        end
      end else if (pos_q != '0) begin
        if (quiet_q == CW'(TMO_CYC - 1)) begin
          pos_q   <= '0;
          quiet_q <= '0;
        end else begin
          quiet_q <= quiet_q + 1'b1;
        end
      end
    end
  end

  assign done_o  = done_q;
  assign frame_o = frame_q;
endmodule

// File: rtl/ps2_host_rx.sv
module ps2_host_rx
  import ps2rx_pkg::*;
#(
  parameter int FILT_LEN  = 8,
  parameter int TMO_CYC   = 250000,
  parameter int INHIB_MIN = 12500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  output logic       ps2_clk_pull_o,
  output logic [7:0] rx_byte_o,
  output logic       rx_full_o,
  input  logic       rd_ack_i,
  output logic       parity_err_o,
  output logic       frame_err_o
);
  localparam int HW = $clog2(INHIB_MIN + 1);

  logic [1:0]         line_s;
  logic               clk_level, clk_fall;
  logic               bit_take, frame_done;
  logic [FRAME_W-1:0] frame;
  logic               shape_ok, par_ok;

  logic [7:0]    byte_q;
  logic          full_q, pull_q, perr_q, ferr_q;
  logic [HW-1:0] hold_q;
  logic          min_met;

  ps2rx_sync #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({ps2_clk_i, ps2_dat_i}),
    .q_o   (line_s)
  );

  ps2rx_deglitch #(.LEN(FILT_LEN)) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_i    (line_s[1]),
    .level_o (clk_level),
    .fall_o  (clk_fall)
  );

  ps2rx_framer #(.TMO_CYC(TMO_CYC)) u_framer (
    .clk     (clk),
    .rst_n   (rst_n),
    .fall_i  (clk_fall),
    .bit_i   (line_s[0]),
    .en_i    (!pull_q),
    .take_o  (bit_take),
    .done_o  (frame_done),
    .frame_o (frame)
  );

  assign shape_ok = frame_shape_ok(frame);
  assign par_ok   = frame_parity_ok(frame);
  assign min_met  = (hold_q >= HW'(INHIB_MIN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      full_q <= 1'b0;
      pull_q <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      hold_q <= '0;
    end else if (frame_done) begin
      // Reception is gated off while pulling, so buffer is empty here.
      if (!shape_ok) begin
        ferr_q <= 1'b1;
        perr_q <= 1'b0;
      end else if (!par_ok) begin
        perr_q <= 1'b1;
        ferr_q <= 1'b0;
      end else begin
        byte_q <= frame_payload(frame);
        full_q <= 1'b1;
        pull_q <= 1'b1;
        hold_q <= '0;
        perr_q <= 1'b0;
        ferr_q <= 1'b0;
      end
    end else begin
      if (full_q && rd_ack_i) full_q <= 1'b0;
      if (pull_q) begin
        if (!min_met) hold_q <= hold_q + 1'b1;
        if (min_met && (!full_q || rd_ack_i)) pull_q <= 1'b0;
      end
    end
  end

  assign ps2_clk_pull_o = pull_q;
  assign rx_byte_o      = byte_q;
  assign rx_full_o      = full_q;
  assign parity_err_o   = perr_q;
  assign frame_err_o    = ferr_q;

  logic unused_level;
  assign unused_level = clk_level ^ bit_take;
endmodule

// File: rtl/ps2_host_rx_checks.sv
module ps2_host_rx_checks #(
  parameter int INHIB_MIN = 12500
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ps2_clk_pull_o,
  input logic [7:0] rx_byte_o,
  input logic       rx_full_o,
  input logic       rd_ack_i,
  input logic       parity_err_o,
  input logic       frame_err_o,
  input logic       frame_done
);
  localparam int PW = $clog2(INHIB_MIN + 2);
  logic [PW-1:0] pull_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pull_run <= '0;
    else if (!ps2_clk_pull_o) pull_run <= '0;
    else if (pull_run < PW'(INHIB_MIN)) pull_run <= pull_run + 1'b1;
  end

  a_r6_pull_while_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full_o |-> ps2_clk_pull_o);

  a_r7_min_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ps2_clk_pull_o) |-> (pull_run >= PW'(INHIB_MIN)));

  a_r8_ack_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full_o && rd_ack_i) |=> !rx_full_o);

  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(parity_err_o && frame_err_o));

  a_r2_fill_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full_o) |-> $past(frame_done));

  a_r12_byte_moves_on_fill: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte_o) |-> $rose(rx_full_o));
endmodule

bind ps2_host_rx ps2_host_rx_checks #(.INHIB_MIN(INHIB_MIN)) u_checks (
  .clk            (clk),
  .rst_n          (rst_n),
  .ps2_clk_pull_o (ps2_clk_pull_o),
  .rx_byte_o      (rx_byte_o),
  .rx_full_o      (rx_full_o),
  .rd_ack_i       (rd_ack_i),
  .parity_err_o   (parity_err_o),
  .frame_err_o    (frame_err_o),
  .frame_done     (frame_done)
);

// File: tb/test_ps2_host_rx.sv
`timescale 1ns/1ps
module test_ps2_host_rx;
  localparam int FILT = 4;
  localparam int TMO  = 300;
  localparam int IMIN = 120;
  localparam int HP   = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dev_clk = 1'b1, dev_dat = 1'b1, rd_ack = 1'b0;
  logic pull, full, perr, ferr;
  logic [7:0] rbyte;
  logic line_clk;

  int errors = 0, checks = 0;
  int run = 0, last_run = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign line_clk = dev_clk & ~pull;

  ps2_host_rx #(.FILT_LEN(FILT), .TMO_CYC(TMO), .INHIB_MIN(IMIN)) i_ps2_host_rx (
    .clk(clk), .rst_n(rst_n), .ps2_clk_i(line_clk), .ps2_dat_i(dev_dat),
    .ps2_clk_pull_o(pull), .rx_byte_o(rbyte), .rx_full_o(full),
    .rd_ack_i(rd_ack), .parity_err_o(perr), .frame_err_o(ferr)
  );

  always @(negedge clk) begin
    if (pull) run++;
    else if (run != 0) begin last_run = run; run = 0; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] mk(input logic [7:0] d, input bit bad_par,
                                     input logic st, input logic sp);
    logic p;
    p = ~^d;
    if (bad_par) p = ~p;
    return {sp, p, d, st};
  endfunction

  task automatic send_bits(input logic [10:0] f, input int n);
    for (int i = 0; i < n; i++) begin
      dev_dat = f[i];
      repeat (HP/2) @(negedge clk);
      dev_clk = 1'b0;
      repeat (HP) @(negedge clk);
      dev_clk = 1'b1;
      repeat (HP/2) @(negedge clk);
    end
    dev_dat = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_release();
    for (int i = 0; i < 1000 && pull; i++) @(negedge clk);
  endtask

  task automatic ack_once();
    @(negedge clk) rd_ack = 1'b1;
    @(negedge clk) rd_ack = 1'b0;
  endtask

  task automatic good_byte(input logic [7:0] d);
    send_bits(mk(d, 0, 1'b0, 1'b1), 11);
    chk(full == 1'b1, "R2 full", full, 1);
    chk(rbyte == d, "R2 byte", rbyte, d);
    chk(!perr && !ferr, "R5 flags clear", {perr, ferr}, 0);
    chk(pull == 1'b1, "R6 pull with full", pull, 1);
    ack_once();
    wait_release();
    chk(!full && !pull, "R8 released", {full, pull}, 0);
  endtask

  task automatic t_reset();
    chk(!full && !pull && !perr && !ferr, "R1 reset flags",
        {full, pull, perr, ferr}, 0);
    chk(rbyte == 8'h00, "R1 reset byte", rbyte, 0);
  endtask

  task automatic t_parity();
    send_bits(mk(8'h6E, 1, 1'b0, 1'b1), 11);
    chk(perr == 1'b1 && ferr == 1'b0, "R3 parity flag", {perr, ferr}, 2);
    chk(!full && !pull, "R3 no store", {full, pull}, 0);
    chk(rbyte == 8'hFF, "R3 byte kept", rbyte, 8'hFF);
  endtask

  task automatic t_framing();
    send_bits(mk(8'h42, 0, 1'b1, 1'b1), 11);
    chk(ferr == 1'b1 && perr == 1'b0, "R4 start bit one", {perr, ferr}, 1);
    chk(!full, "R4 start dropped", full, 0);
    send_bits(mk(8'h42, 1, 1'b0, 1'b0), 11);
    chk(ferr == 1'b1 && perr == 1'b0, "R4 stop bit zero", {perr, ferr}, 1);
    chk(!full && rbyte == 8'hFF, "R4 stop dropped", {full, rbyte}, 8'hFF);
    repeat (TMO) @(negedge clk);
    good_byte(8'h24);
    chk(!perr && !ferr, "R5 good clears", {perr, ferr}, 0);
  endtask

  task automatic t_min_inhibit();
    send_bits(mk(8'h99, 0, 1'b0, 1'b1), 11);
    ack_once();
    chk(!full && pull, "R7 pull kept after early read", {full, pull}, 1);
    wait_release();
    repeat (2) @(negedge clk);
    chk(last_run >= IMIN && last_run <= IMIN + 1, "R7 inhibit length",
        last_run, IMIN);
  endtask

  task automatic t_late_release();
    send_bits(mk(8'hC3, 0, 1'b0, 1'b1), 11);
    repeat (IMIN + 40) @(negedge clk);
    chk(full && pull, "R6 held while full", {full, pull}, 3);
    @(negedge clk) rd_ack = 1'b1;
    @(negedge clk) rd_ack = 1'b0;
    chk(!full && !pull, "R8 same-edge release", {full, pull}, 0);
  endtask

  task automatic t_inhibit_ignore();
    send_bits(mk(8'h5A, 0, 1'b0, 1'b1), 11);
    send_bits(mk(8'h0F, 0, 1'b0, 1'b1), 6);
    chk(full && rbyte == 8'h5A, "R9 byte kept under inhibit", rbyte, 8'h5A);
    ack_once();
    wait_release();
    repeat (10) @(negedge clk);
    chk(!full && !perr && !ferr, "R9 no stray frame", {full, perr, ferr}, 0);
    send_bits(mk(8'h11, 0, 1'b0, 1'b1), 11);
    chk(full && rbyte == 8'h11 && !ferr && !perr, "R9 next frame intact",
        rbyte, 8'h11);
    ack_once();
    wait_release();
  endtask

  task automatic t_timeout();
    send_bits(mk(8'hF0, 0, 1'b0, 1'b1), 5);
    repeat (TMO + 40) @(negedge clk);
    send_bits(mk(8'h3A, 0, 1'b0, 1'b1), 11);
    chk(full && rbyte == 8'h3A && !perr && !ferr, "R10 realigned", rbyte, 8'h3A);
    ack_once();
    wait_release();
  endtask

  task automatic t_glitch();
    repeat (20) @(negedge clk);
    dev_clk = 1'b0;
    repeat (2) @(negedge clk);
    dev_clk = 1'b1;
    repeat (40) @(negedge clk);
    send_bits(mk(8'hB7, 0, 1'b0, 1'b1), 11);
    chk(full && rbyte == 8'hB7 && !perr && !ferr, "R11 spike ignored",
        rbyte, 8'hB7);
    ack_once();
    wait_release();
  endtask

  task automatic t_ack_empty();
    ack_once();
    repeat (3) @(negedge clk);
    chk(!full && !pull, "R12 idle ack no effect", {full, pull}, 0);
    chk(rbyte == 8'hB7, "R12 byte unchanged", rbyte, 8'hB7);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    good_byte(8'hA5);
    good_byte(8'h01);
    good_byte(8'h80);
    good_byte(8'h00);
    good_byte(8'hFF);
    t_parity();
    t_framing();
    t_min_inhibit();
    t_late_release();
    t_inhibit_ignore();
    t_timeout();
    t_glitch();
    t_ack_empty();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule